// File: doc/BRIEF.md
# Synchronous Serial Port with Automatic Block Transfer

This block is an 8-bit clocked serial shifter with a clock pin, a data-in pin and a data-out pin. Software chooses the bit order and where the serial clock comes from. In master mode an internal 8-bit divider produces the clock and drives the clock pin. In slave mode the clock pin is an input, and a two-flop synchroniser brings it into the system clock domain. The clock idles high. Input data is sampled on the rising edge. Output data changes after the falling edge.

A 32-byte buffer feeds every transfer. Software loads the buffer through a small register port, programs a bit count between 1 and 256, and sets the go bit. The port then streams the bits with no further service. Each outgoing byte is read from a buffer slot, and the received bits are written back into that same slot. The next slot is loaded into the shift register as soon as a byte completes. In master mode a buffer-transfer gap, lasting one extra half-period with the clock held high, separates consecutive bytes. A single done flag, which is also the interrupt output, rises when the last bit has been sampled.

Register map: addresses 0 to 31 are buffer slots. Address 32 is control. Address 33 is the divider value D. Address 34 is the bit count.

Top module: `ssp_block`

## Requirements
- R1: After reset, sck_o is 1, sck_oe is 0, sdo is 1, irq_done is 0, and a read of control (address 32) returns 0.
- R2: Control bit 0 selects the bit order. When it is 1 each byte goes out bit 7 first and received bits shift in at bit 0. When it is 0 each byte goes out bit 0 first and received bits shift in at bit 7.
- R3: In master mode (control bit 1 = 1) each clock half-period lasts 2*(D+1) system clocks, so no clock period is shorter than 4 system clocks.
- R4: sdi is sampled on the rising clock edge. sdo takes its next bit on the falling edge; in master mode this happens in the same system clock in which sck_o falls. The first bit appears on sdo when go is written.
- R5: Writing control with bit 7 set starts a transfer of N bits, where N is the bit count register and a value of 0 means 256. Exactly N rising clock edges occur.
- R6: After every 8th bit, the shifted byte is written back to the slot it came from and the next slot is loaded. In master mode the falling edge that follows the 8th rising edge comes one extra half-period late.
- R7: When N is not a multiple of 8, the final slot holds that byte after only the remaining k shifts.
- R8: irq_done is set when the last bit is sampled and is cleared by go. In master mode it rises in the same system clock as the last sck_o rise; in slave mode it rises on the third system clock edge after sck_i rises. Control bit 7 reads as busy.
- R9: While busy, writes to buffer slots, the divider and control are ignored.
- R10: In slave mode sck_oe is 0 and the transfer is clocked by sck_i through a two-flop synchroniser. sdi must be held stable while sck_i is high.
- R11: While the port is idle in master mode, sck_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sck_i | input | 1 | Clock pin input (slave mode) |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin drive enable (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq_done | output | 1 | Transfer-done flag and interrupt |

## Verification
In master mode both sdo and irq_done change in the same system clock as the matching sck_o edge. The bench therefore polls sck_o at every falling system clock edge and checks sdi, sdo and done at the poll where it first sees the edge. It timestamps each falling sck_o edge and compares the spacing with 4*(D+1) cycles inside a byte and 6*(D+1) cycles across a byte boundary. In slave mode the synchroniser adds three system clock edges. The bench holds every sck_i level for four cycles, reads sdo just before it raises sck_i, and, after the final rise, checks that done is still low two cycles later and high three cycles later. Buffer contents are read back only after done, and they are compared with bytes the bench derives from its own random transmit and receive streams.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        CK_IDLE,
        CK_LOW,
        CK_HIGH,
        CK_GAP
    } ck_state_e;

    typedef struct packed {
        logic master;
        logic msb_first;
    } cfg_t;

    localparam int HALF_W = 10;

    // Bit presented on the data line for the current shift state.
    function automatic logic out_bit(byte_t s, logic msb);
        return msb ? s[7] : s[0];
    endfunction

    // Shift one received bit into the shift register.
    function automatic byte_t shift_in(byte_t s, logic msb, logic b);
        return msb ? {s[6:0], b} : {b, s[7:1]};
    endfunction

    // Half-period length in system clocks: 2*(D+1), never below 2.
    function automatic logic [HALF_W-1:0] half_len(byte_t d);
        return ({2'b00, d} + 10'd1) << 1;
    endfunction

endpackage

// File: rtl/ssp_buf.sv
module ssp_buf #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  ssp_pkg::byte_t wdata,
    input  logic [AW-1:0] raddr_a,
    output ssp_pkg::byte_t rdata_a,
    input  logic [AW-1:0] raddr_b,
    output ssp_pkg::byte_t rdata_b
);
    ssp_pkg::byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise_ev,
    output logic fall_ev
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= 3'b111;
        else     sh <= {sh[1:0], pin};
    end

    assign rise_ev = sh[1] & ~sh[2];
    assign fall_ev = ~sh[1] & sh[2];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic              byte_end,
    input  logic [HALF_W-1:0] half,
    output logic              sck,
    output logic              rise_ev,
    output logic              fall_ev
);
    ck_state_e         st;
    logic [HALF_W-1:0] tmr;
    logic              gap_q;
    logic              expire;

    assign expire = (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CK_IDLE;
            tmr   <= '0;
            gap_q <= 1'b0;
        end else begin
            unique case (st)
                CK_IDLE: if (start) begin
                    st    <= CK_LOW;
                    tmr   <= half - 1'b1;
                    gap_q <= 1'b0;
                end
                CK_LOW: if (expire) begin
                    st  <= CK_HIGH;
                    tmr <= half - 1'b1;
                    if (byte_end) gap_q <= 1'b1;
                end else tmr <= tmr - 1'b1;
                CK_HIGH: if (expire) begin
                    if (!run) st <= CK_IDLE;
                    else if (gap_q) begin
                        st    <= CK_GAP;
                        tmr   <= half - 1'b1;
                        gap_q <= 1'b0;
                    end else begin
                        st  <= CK_LOW;
                        tmr <= half - 1'b1;
                    end
                end else tmr <= tmr - 1'b1;
                CK_GAP: if (expire) begin
                    st  <= CK_LOW;
                    tmr <= half - 1'b1;
                end else tmr <= tmr - 1'b1;
                default: st <= CK_IDLE;
            endcase
        end
    end

    assign sck     = (st != CK_LOW);
    assign rise_ev = (st == CK_LOW) && expire;
    assign fall_ev = ((st == CK_HIGH) && expire && run && !gap_q) ||
                     ((st == CK_GAP) && expire);
endmodule

// File: rtl/ssp_block.sv
module ssp_block
    import ssp_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH * 8)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [AW:0] reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    input  logic        sdi,
    output logic        sdo,
    output logic        irq_done
);
    localparam int          NW       = CW + 1;
    localparam logic [NW-1:0] MAXBITS = NW'(DEPTH * 8);
    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_DIV  = AW'(1);
    localparam logic [AW-1:0] A_CNT  = AW'(2);

    cfg_t          cfg;
    byte_t         div_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    byte_t         sreg;
    logic [AW-1:0] idx;
    logic [NW-1:0] nbit_q;
    logic [NW-1:0] total;

    logic  is_reg, wr_ctrl, go, last, byte_end;
    logic  m_sck, m_rise, m_fall, s_rise, s_fall, rise_e, fall_e;
    logic  eng_we, buf_we;
    byte_t sh, buf_rd_a, buf_rd_b, buf_wd;
    logic [AW-1:0] buf_wa, eng_ra;

    assign is_reg  = reg_addr[AW];
    assign wr_ctrl = reg_we && !busy_q && is_reg && (reg_addr[AW-1:0] == A_CTRL);
    assign go      = wr_ctrl && reg_wdata[7];
    assign total   = (cnt_q == '0) ? MAXBITS : NW'(cnt_q);
    assign last    = (nbit_q == total - 1'b1);
    assign byte_end = (nbit_q[2:0] == 3'd7) && !last;
    assign sh      = shift_in(sreg, cfg.msb_first, sdi);

    ssp_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .start   (go && reg_wdata[1]),
        .run     (busy_q),
        .byte_end(byte_end),
        .half    (half_len(div_q)),
        .sck     (m_sck),
        .rise_ev (m_rise),
        .fall_ev (m_fall)
    );

    ssp_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin    (sck_i),
        .rise_ev(s_rise),
        .fall_ev(s_fall)
    );

    assign rise_e = busy_q && (cfg.master ? m_rise : s_rise);
    assign fall_e = busy_q && (cfg.master ? m_fall : s_fall);

    // Buffer: engine write-back has priority; register writes only while idle.
    assign eng_we = rise_e && (last || nbit_q[2:0] == 3'd7);
    assign buf_we = eng_we || (reg_we && !busy_q && !is_reg);
    assign buf_wa = eng_we ? idx : reg_addr[AW-1:0];
    assign buf_wd = eng_we ? sh  : reg_wdata;
    assign eng_ra = busy_q ? idx + 1'b1 : '0;

    ssp_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk    (clk),
        .we     (buf_we),
        .waddr  (buf_wa),
        .wdata  (buf_wd),
        .raddr_a(reg_addr[AW-1:0]),
        .rdata_a(buf_rd_a),
        .raddr_b(eng_ra),
        .rdata_b(buf_rd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sreg   <= '0;
            sdo    <= 1'b1;
            idx    <= '0;
            nbit_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg <= '{master: reg_wdata[1], msb_first: reg_wdata[0]};
                if (reg_wdata[7]) begin
                    busy_q <= 1'b1;
                    done_q <= 1'b0;
                    sreg   <= buf_rd_b;
                    sdo    <= out_bit(buf_rd_b, reg_wdata[0]);
                    idx    <= '0;
                    nbit_q <= '0;
                end
            end
            if (reg_we && !busy_q && is_reg && reg_addr[AW-1:0] == A_DIV) div_q <= reg_wdata;
            if (reg_we && !busy_q && is_reg && reg_addr[AW-1:0] == A_CNT) cnt_q <= reg_wdata[CW-1:0];
            if (fall_e) sdo <= out_bit(sreg, cfg.msb_first);
            if (rise_e) begin
                nbit_q <= nbit_q + 1'b1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    sreg   <= sh;
                end else if (nbit_q[2:0] == 3'd7) begin
                    idx  <= idx + 1'b1;
                    sreg <= buf_rd_b;
                end else begin
                    sreg <= sh;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (!is_reg) reg_rdata = buf_rd_a;
        else if (reg_addr[AW-1:0] == A_CTRL) reg_rdata = {busy_q, 5'b0, cfg.master, cfg.msb_first};
        else if (reg_addr[AW-1:0] == A_DIV)  reg_rdata = div_q;
        else if (reg_addr[AW-1:0] == A_CNT)  reg_rdata = 8'(cnt_q);
    end

    assign sck_oe   = cfg.master;
    assign sck_o    = cfg.master ? m_sck : 1'b1;
    assign irq_done = done_q;
endmodule

// File: rtl/ssp_block_chk.sv
module ssp_block_chk #(
    parameter int NW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          sck_o,
    input logic          sck_oe,
    input logic          sdo,
    input logic [NW-1:0] nbit,
    input logic [NW-1:0] total
);
    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    // R11
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !busy) |-> sck_o);

    // R4
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(sdo));

    // R5
    nbit_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (nbit < total));

    // R3
    min_half_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && sck_oe && (sck_o != $past(sck_o))) |=> $stable(sck_o));
endmodule

bind ssp_block ssp_block_chk #(.NW(NW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy_q),
    .done  (done_q),
    .sck_o (sck_o),
    .sck_oe(sck_oe),
    .sdo   (sdo),
    .nbit  (nbit_q),
    .total (total)
);

// File: tb/ssp_block_tb.sv
module ssp_block_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe;
    logic       sdi = 1'b0;
    logic       sdo, irq_done;

    int nchk = 0, nfail = 0, cyc = 0;

    localparam logic [5:0] A_CTRL = 6'd32, A_DIV = 6'd33, A_CNT = 6'd34;

    ssp_block u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_i),
        .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .irq_done(irq_done)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] mshift(logic [7:0] s, bit msb, bit b);
        if (msb) return {s[6:0], b};
        return {b, s[7:1]};
    endfunction

    task automatic run_xfer(input bit master, input bit msb, input int div,
                            input int nbits, input bit poke);
        logic [7:0] txb [32];
        logic [7:0] expb[32];
        bit rxb[256];
        bit txexp[256];
        bit txgot[256];
        int ft[256];
        int nfall = 0, nrise = 0, derr = 0, perr = 0, terr = 0, berr = 0;
        int h, t0, nbytes;
        bit prev, cur;
        logic [7:0] r;

        for (int i = 0; i < 32; i++) begin
            txb[i] = 8'($urandom);
            reg_wr(6'(i), txb[i]);
        end
        for (int i = 0; i < 256; i++) rxb[i] = 1'($urandom);
        nbytes = (nbits + 7) / 8;
        for (int b = 0; b < 32; b++) begin
            expb[b] = txb[b];
            for (int j = 0; j < 8; j++) begin
                if (8*b + j < nbits) begin
                    txexp[8*b+j] = msb ? txb[b][7-j] : txb[b][j];
                    expb[b] = mshift(expb[b], msb, rxb[8*b+j]);
                end
            end
        end
        reg_wr(A_DIV, 8'(div));
        reg_wr(A_CNT, 8'(nbits % 256));
        reg_wr(A_CTRL, {1'b1, 5'b0, master, msb});
        // R8: go clears done
        chk(irq_done == 1'b0, "R8 done cleared by go", irq_done, 0);
        h = 2 * (div + 1);

        if (master) begin
            prev = 1'b1;
            t0 = cyc;
            while (1) begin
                cur = sck_o;
                if (prev && !cur) begin
                    if (nfall < 256) begin ft[nfall] = cyc; sdi = rxb[nfall]; end
                    nfall++;
                end
                if (!prev && cur) begin
                    if (nrise < 256) txgot[nrise] = sdo;
                    if (irq_done != (nrise == nbits - 1)) derr++;
                    nrise++;
                end
                prev = cur;
                if (irq_done) break;
                if (poke && (cyc - t0) == 5) begin
                    reg_rd(A_CTRL, r);
                    // R8: busy reads as control bit 7
                    chk(r[7] == 1'b1, "R8 busy bit", r[7], 1);
                    reg_wr(6'd31, ~txb[31]);
                    reg_wr(A_DIV, 8'd0);
                    reg_wr(A_CTRL, 8'h80);
                end
                @(negedge clk);
                if (cyc - t0 > 60000) break;
            end
            for (int i = 1; i < nfall && i < nbits; i++)
                if (ft[i] - ft[i-1] != ((i % 8 == 0) ? 3*h : 2*h)) perr++;
            // R3 R6: fall spacing, extra half-period at byte boundaries
            chk(perr == 0, "R3 R6 master clock timing", perr, 0);
            // R8: done rises with the final sck_o rise
            chk(derr == 0, "R8 done timing master", derr, 0);
            // R11: clock back high after transfer
            chk(sck_o == 1'b1, "R11 sck idle high", sck_o, 1);
        end else begin
            for (int i = 0; i < nbits; i++) begin
                @(negedge clk);
                sck_i = 1'b0;
                sdi = rxb[i];
                repeat (4) @(negedge clk);
                txgot[i] = sdo;
                sck_i = 1'b1;
                nrise++;
                if (i == nbits - 1) begin
                    repeat (2) @(negedge clk);
                    // R8: not yet set two cycles after the rise
                    chk(irq_done == 1'b0, "R8 done slave early", irq_done, 0);
                    @(negedge clk);
                    // R8: set three cycles after the rise
                    chk(irq_done == 1'b1, "R8 done slave", irq_done, 1);
                end else begin
                    repeat (3) @(negedge clk);
                end
            end
            // R10: pin not driven in slave mode
            chk(sck_oe == 1'b0, "R10 slave oe", sck_oe, 0);
        end

        // R5: exact number of rising edges
        chk(nrise == nbits, "R5 rise count", nrise, nbits);
        for (int i = 0; i < nbits && i < 256; i++) if (txgot[i] != txexp[i]) terr++;
        // R2 R4: transmitted stream and bit order
        chk(terr == 0, "R2 R4 transmit stream", terr, 0);
        for (int b = 0; b < 32; b++) begin
            reg_rd(6'(b), r);
            if (r != expb[b]) berr++;
        end
        // R6: received bytes written back to their slots
        chk(berr == 0, "R6 buffer contents", berr, 0);
        if (nbits % 8 != 0) begin
            reg_rd(6'(nbytes - 1), r);
            // R7: partial final byte
            chk(r == expb[nbytes-1], "R7 partial byte", r, expb[nbytes-1]);
        end
        if (poke) begin
            reg_rd(6'd31, r);
            // R9: buffer write during transfer ignored
            chk(r == txb[31], "R9 write ignored", r, txb[31]);
        end
    endtask

    initial begin
        wait (cyc > 150000);
        chk(1'b0, "watchdog", cyc, 150000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(sck_o == 1'b1 && sck_oe == 1'b0, "R1 clock pin", {sck_o, sck_oe}, 2);
        chk(sdo == 1'b1 && irq_done == 1'b0, "R1 sdo/done", {sdo, irq_done}, 2);
        reg_rd(A_CTRL, r);
        chk(r == 8'h00, "R1 control", r, 0);

        run_xfer(1'b1, 1'b1, 0, 8, 1'b0);
        run_xfer(1'b1, 1'b0, 0, 256, 1'b0);
        run_xfer(1'b1, 1'b1, 255, 3, 1'b0);
        run_xfer(1'b1, 1'b0, 50, 8, 1'b1);
        run_xfer(1'b0, 1'b1, 0, 20, 1'b0);
        run_xfer(1'b0, 1'b0, 0, 13, 1'b0);
        run_xfer(1'b0, 1'b1, 0, 256, 1'b0);
        for (int k = 0; k < 6; k++)
            run_xfer(1'($urandom), 1'($urandom), int'($urandom % 4),
                     1 + int'($urandom % 256), 1'b0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule